// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a memory-mapped watchdog. It keeps a down-counter in its own watchdog clock domain. Software arms it by writing a load value and choosing an expiry action. Each later write of the load value restarts the countdown, and that write is the keepalive. When the count runs out, the block does one of four things, chosen at run time: nothing, raise an interrupt level, raise a non-maskable interrupt level, or send a fixed-length reset request to the chip's reset sequencer.

Load writes move from the bus clock into the watchdog clock through a request/acknowledge handshake. While a load is in flight, a pending bit in the control word stays set. Software polls that bit before it enables an action. A sticky flag records that the block has requested a chip reset. The flag lives through the system reset that follows, so that boot code can read it. Only the power-on reset, or an explicit clear by software, resets it.

Top module: `wdog_sel`

## Requirements
- R1: After power-on reset, the control word reads 0, the load word reads 0xFFFFFFFF, and `irq`, `nmi` and `rst_req` are low.
- R2: A write to the load word at address 0x4 sets the pending bit (control bit 2) from the next bus cycle. The bit clears on its own once the value has reached the counter and the handshake has completed.
- R3: The counter decrements once per watchdog clock, and only while the action field (control bits [1:0]) is non-zero. With action 0 the count is frozen. After the count reaches zero it holds there.
- R4: Action 1 drives `irq` high once the count expires, and `irq` stays high. `nmi` stays low while this happens.
- R5: Action 2 drives `nmi` high once the count expires, and `nmi` stays high. `irq` stays low while this happens.
- R6: Action 3 makes `rst_req` a single pulse of exactly 16 watchdog clocks. The pulse fires once per load, and `irq` and `nmi` stay low.
- R7: A completed load write (keepalive) clears `irq` and `nmi` and restarts the countdown from the new value.
- R8: Writing action 0 clears `irq` and `nmi` within a few watchdog clocks.
- R9: Control bit 31 reads 1 after the block has requested a reset, and it survives `sys_rst_n`. It returns to 0 on `por_n`, or on a control write with bit 31 set.
- R10: A load write that arrives while the pending bit is set is dropped. The load word keeps the earlier value.
- R11: The control word sits at address 0x0 and the load word at address 0x4. Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| wd_clk | input | 1 | Watchdog counting clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, keeps the last-reset flag |
| addr | input | 4 | Register byte address |
| we | input | 1 | Write strobe, one bus cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt level on expiry |
| nmi | output | 1 | Non-maskable interrupt level on expiry |
| rst_req | output | 1 | Chip reset request pulse |

## Verification
A counter that decrements while the action is 0, or loads the wrong value, moves the edge of `irq` or `nmi` by many watchdog clocks. The bench therefore samples these outputs on both sides of the expected expiry window. A broken handshake shows within about twenty bus cycles, either as a pending bit that never clears or as a dropped write that changes the readback. A wrong reset-pulse counter shows as a pulse length other than 16. A flag wired to the wrong reset shows on the first control read after `sys_rst_n` or `por_n`.

// File: rtl/wdog_sel.sv
module wdog_sel #(
  parameter int CW      = 32,
  parameter int AW      = 4,
  parameter int RST_LEN = 16
) (
  input  logic          bus_clk,
  input  logic          wd_clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq,
  output logic          nmi,
  output logic          rst_req
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_TIMER = AW'(4);
  localparam int RCW = $clog2(RST_LEN + 1);

  logic          rst_n;
  logic [1:0]    act, as1, act_s;
  logic [CW-1:0] ld_val, cnt;
  logic          req, ack, ack_s1, ack_s2, pend, last_q, fired;
  logic [2:0]    rr, rq;
  logic [RCW-1:0] rcnt;
  logic          wr_ctrl, wr_tmr, load, fire;

  assign rst_n   = por_n & sys_rst_n;
  assign pend    = req | ack_s2;
  assign wr_ctrl = we && addr == A_CTRL;
  assign wr_tmr  = we && addr == A_TIMER && !pend;

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      act    <= '0;
      ld_val <= '1;
      req    <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      rr     <= '0;
    end else begin
      ack_s1 <= ack;
      ack_s2 <= ack_s1;
      rr     <= {rr[1:0], rst_req};
      if (wr_ctrl) act <= wdata[1:0];
      if (wr_tmr) begin
        ld_val <= wdata[CW-1:0];
        req    <= 1'b1;
      end else if (ack_s2) begin
        req <= 1'b0;
      end
    end

  always_ff @(posedge bus_clk or negedge por_n)
    if (!por_n)                   last_q <= 1'b0;
    else if (rr[1] && !rr[2])     last_q <= 1'b1;
    else if (wr_ctrl && wdata[31]) last_q <= 1'b0;

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)       rdata = {last_q, 28'd0, pend, act};
    else if (addr == A_TIMER) rdata = 32'(ld_val);
  end

  assign ack     = rq[1];
  assign load    = rq[1] && !rq[2];
  assign fire    = act_s != 2'd0 && cnt == '0 && !fired && !load;
  assign rst_req = rcnt != '0;

  always_ff @(posedge wd_clk or negedge rst_n)
    if (!rst_n) begin
      rq    <= '0;
      as1   <= '0;
      act_s <= '0;
      cnt   <= '1;
      fired <= 1'b0;
      irq   <= 1'b0;
      nmi   <= 1'b0;
      rcnt  <= '0;
    end else begin
      rq    <= {rq[1:0], req};
      as1   <= act;
      act_s <= as1;
      if (load) begin
        cnt   <= ld_val;
        fired <= 1'b0;
      end else begin
        if (act_s != 2'd0 && cnt != '0) cnt <= cnt - 1'b1;
        if (fire) fired <= 1'b1;
      end
      if (load || act_s == 2'd0) begin
        irq <= 1'b0;
        nmi <= 1'b0;
      end else if (fire) begin
        irq <= act_s == 2'd1;
        nmi <= act_s == 2'd2;
      end
      if (fire && act_s == 2'd3) rcnt <= RCW'(RST_LEN);
      else if (rcnt != '0)       rcnt <= rcnt - 1'b1;
    end
endmodule

// File: rtl/wdog_sel_chk.sv
module wdog_sel_chk #(
  parameter int CW      = 32,
  parameter int AW      = 4,
  parameter int RST_LEN = 16
) (
  input logic          bus_clk,
  input logic          wd_clk,
  input logic          rst_n,
  input logic          por_n,
  input logic          we,
  input logic          wdata31,
  input logic [AW-1:0] addr,
  input logic          pend,
  input logic [CW-1:0] ld_val,
  input logic          last_q,
  input logic [1:0]    act_s,
  input logic          irq,
  input logic          nmi,
  input logic          rst_req
);
  localparam int HW = $clog2(RST_LEN + 2);
  logic [HW-1:0] hi;

  always_ff @(posedge wd_clk or negedge rst_n)
    if (!rst_n)       hi <= '0;
    else if (rst_req) hi <= hi + 1'b1;
    else              hi <= '0;

  // R2
  timer_pend_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (we && addr == AW'(4)) |=> pend);
  // R10
  load_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    pend |=> $stable(ld_val));
  // R8
  act_off_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (act_s == 2'd0) |=> (!irq && !nmi));
  // R4
  irq_nmi_excl_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    !(irq && nmi));
  // R6
  rst_len_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    hi <= HW'(RST_LEN));
  // R6
  rst_fall_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    $fell(rst_req) |-> hi == HW'(RST_LEN));
  // R9
  flag_clr_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
    $fell(last_q) |-> $past(we && addr == AW'(0) && wdata31));
endmodule

bind wdog_sel wdog_sel_chk #(.CW(CW), .AW(AW), .RST_LEN(RST_LEN)) chk_i (
  .bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n), .por_n(por_n),
  .we(we), .wdata31(wdata[31]), .addr(addr), .pend(pend), .ld_val(ld_val),
  .last_q(last_q), .act_s(act_s), .irq(irq), .nmi(nmi), .rst_req(rst_req));

// File: tb/wdog_sel_tb_top.sv
`timescale 1ns/1ps
module wdog_sel_tb_top;
  logic bus_clk = 1'b0, wd_clk = 1'b0, por_n = 1'b0, sys_rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic irq, nmi, rst_req;

  always #2.5 bus_clk = ~bus_clk;
  always #7   wd_clk  = ~wd_clk;

  wdog_sel dut_i (.bus_clk(bus_clk), .wd_clk(wd_clk), .por_n(por_n),
    .sys_rst_n(sys_rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .irq(irq), .nmi(nmi), .rst_req(rst_req));

  typedef struct { string rq; int sel; logic [31:0] exp; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, meas = 0;
  bit done = 1'b0;

  initial forever begin
    @(negedge bus_clk);
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      case (it.sel)
        0: got = rdata;
        1: got = 32'(irq);
        2: got = 32'(nmi);
        3: got = 32'(rst_req);
        default: got = 32'(meas);
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d got=%h exp=%h", it.rq, it.sel, got, it.exp);
      end
    end
  end

  task automatic chk(string rq, int sel, logic [31:0] exp);
    #1;
    q.push_back('{rq, sel, exp});
    while (q.size() != 0) @(negedge bus_clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge bus_clk); addr = a; wdata = d; we = 1'b1;
    @(negedge bus_clk); we = 1'b0;
  endtask

  task automatic rd_chk(string rq, logic [3:0] a, logic [31:0] exp);
    @(negedge bus_clk); addr = a;
    chk(rq, 0, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      @(negedge bus_clk); addr = 4'h0; #1;
      if (!rdata[2]) break;
    end
  endtask

  task automatic wd_wait(int n);
    repeat (n) @(posedge wd_clk);
  endtask

  task automatic fire_reset();
    wr(4'h0, 32'h0);
    wr(4'h4, 32'd10);
    wait_idle();
    wr(4'h0, 32'h3);
    for (int i = 0; i < 100; i++) begin
      @(posedge wd_clk); #1;
      if (rst_req) break;
    end
    meas = rst_req ? 1 : 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge wd_clk); #1;
      if (!rst_req) break;
      meas++;
    end
    chk("R6 reset pulse length", 4, 32'd16);
    chk("R6 irq quiet", 1, 32'd0);
    chk("R6 nmi quiet", 2, 32'd0);
    wd_wait(20);
    chk("R6 pulse fires once", 3, 32'd0);
    @(negedge bus_clk); sys_rst_n = 1'b0;
    repeat (3) @(negedge bus_clk); sys_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    rd_chk("R9 flag after system reset", 4'h0, 32'h8000_0000);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge bus_clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    rd_chk("R1 ctrl reset", 4'h0, 32'h0);
    rd_chk("R1 timer reset", 4'h4, 32'hFFFF_FFFF);
    chk("R1 irq reset", 1, 32'd0);
    chk("R1 nmi reset", 2, 32'd0);
    chk("R1 rst_req reset", 3, 32'd0);

    wr(4'h4, 32'd40);
    rd_chk("R2 pending set", 4'h0, 32'h4);
    wr(4'h4, 32'd7);
    wait_idle();
    rd_chk("R2 pending clears", 4'h0, 32'h0);
    rd_chk("R10 write during pending dropped", 4'h4, 32'd40);
    rd_chk("R11 unmapped address", 4'h8, 32'h0);

    wd_wait(60);
    chk("R3 frozen with action 0", 1, 32'd0);
    wr(4'h0, 32'h1);
    wd_wait(34);
    chk("R3 not expired early", 1, 32'd0);
    wd_wait(16);
    chk("R4 irq on expiry", 1, 32'd1);
    chk("R4 nmi stays low", 2, 32'd0);
    wd_wait(30);
    chk("R4 irq held", 1, 32'd1);

    wr(4'h4, 32'd50);
    wait_idle();
    chk("R7 keepalive clears irq", 1, 32'd0);
    wd_wait(34);
    chk("R7 count restarted", 1, 32'd0);
    wd_wait(25);
    chk("R7 expires again", 1, 32'd1);
    wr(4'h0, 32'h0);
    wd_wait(4);
    chk("R8 action 0 clears irq", 1, 32'd0);

    wr(4'h4, 32'd30);
    wait_idle();
    wr(4'h0, 32'h2);
    wd_wait(20);
    chk("R5 nmi not early", 2, 32'd0);
    wd_wait(20);
    chk("R5 nmi on expiry", 2, 32'd1);
    chk("R5 irq stays low", 1, 32'd0);
    wr(4'h0, 32'h0);
    wd_wait(4);
    chk("R8 action 0 clears nmi", 2, 32'd0);

    fire_reset();
    rd_chk("R1 timer after system reset", 4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'h8000_0000);
    rd_chk("R9 flag cleared by write", 4'h0, 32'h0);

    fire_reset();
    @(negedge bus_clk); por_n = 1'b0;
    repeat (3) @(negedge bus_clk); por_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    rd_chk("R9 flag cleared by power-on reset", 4'h0, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule